// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog down-counter that runs from a slow tick input rather than from the bus clock. Software drives it through four 32-bit word registers: a command register that takes 16-bit key values, a prescaler-code register, a reload-value register and a read-only status register. Configuration is write-protected. The prescaler and reload registers accept data only after the unlock key has been written, and any other key value locks them again.

Once the start key has been written, the counter cannot be stopped. Only the block reset returns it to idle. Each tick passes through a programmable divider (4 to 256) before it reaches the 12-bit counter. Software keeps the system alive by writing the reload key, which refills the counter. If the counter runs down instead, the block issues a one-clock reset request and refills itself.

Accepted configuration writes raise a pending flag in the status register. Each flag stays set for a fixed number of tick pulses, which models the crossing into the slow domain.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rstReq` is low, the counter is idle, the prescaler register reads 0, the reload register reads 0xFFF and the status register reads 0.
- R2: Reads are combinational on `busAddr`. Offset 0x4 returns the 3-bit prescaler code in bits 2:0. Offset 0x8 returns the reload value in bits 11:0. Offset 0xC returns the status, with bit 0 for prescaler-update pending and bit 1 for reload-update pending. Offset 0x0 and all other addresses read 0.
- R3: Writing 0x5555 into bits 15:0 at offset 0x0 grants write access. Any other value written at offset 0x0 removes it.
- R4: A write to offset 0x4 or 0x8 made without write access changes nothing.
- R5: Writing 0xCCCC at offset 0x0 starts the counter. No later key value, including 0x0000, stops it.
- R6: While the counter runs, it steps once every 4<<code `tickIn` pulses for codes 0 to 6. Code 7 divides by 256, the same as code 6.
- R7: If a counter step occurs while the counter holds 1 or 0, the counter is loaded from the reload register and `rstReq` is high for exactly the next clock cycle. With a reload value N≥1 and a full divider period D, the request therefore follows the N·D-th tick after a refill.
- R8: Writing 0xAAAA at offset 0x0 loads the counter from the reload register. In the same cycle this overrides a step, including one that would expire the counter, so no request is issued.
- R9: An accepted prescaler or reload write sets its pending flag. The flag clears after SYNC_TICKS (default 2) further `tickIn` pulses, and a new accepted write restarts the count.
- R10: `rstReq` is never raised while the counter has not been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low reset |
| tickIn | input | 1 | One-clock pulse from the slow time base |
| busWr | input | 1 | Write strobe for the addressed register |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
Register effects appear on the clock edge that samples the write. A read made at the next falling edge therefore already shows the new value or the new status, and the bench samples every result at that falling edge. `rstReq` rises one edge after the tick that expires the counter. The bench counts tick cycles from a refill to the first high sample, which gives the expected N·D exactly. Per-cycle comparisons against a bench model, built from the requirements, cover the random sequences. That model is updated at the same edge the design uses.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RELOAD = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

  localparam int OFS_KEY  = 'h0;
  localparam int OFS_PSC  = 'h4;
  localparam int OFS_RLD  = 'h8;
  localparam int OFS_STAT = 'hC;

  // strobes from control to datapath
  typedef struct packed {
    logic cntReload;
    logic pscLoad;
    logic rldLoad;
  } kwdtStrobe_t;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  keyIn,
  output kwdtStrobe_t       strobe,
  output logic              running,
  output logic [1:0]        busyFlags
);
  localparam int BW = $clog2(SYNC_TICKS + 1);

  logic keyWr, pscWr, rldWr, accessEn;

  assign keyWr = busWr && (busAddr == ADDR_W'(OFS_KEY));
  assign pscWr = busWr && (busAddr == ADDR_W'(OFS_PSC));
  assign rldWr = busWr && (busAddr == ADDR_W'(OFS_RLD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessEn <= 1'b0;
      running  <= 1'b0;
    end else if (keyWr) begin
      accessEn <= (keyIn == KEY_UNLOCK);
      if (keyIn == KEY_START) running <= 1'b1;
    end
  end

  always_comb begin
    strobe.cntReload = keyWr && (keyIn == KEY_RELOAD);
    strobe.pscLoad   = pscWr && accessEn;
    strobe.rldLoad   = rldWr && accessEn;
  end

  // one pending-flag lane per configuration register: 0 prescaler, 1 reload
  for (genvar g = 0; g < 2; g++) begin : gLane
    logic          loadLane;
    logic [BW-1:0] busyCnt;
    assign loadLane = (g == 0) ? strobe.pscLoad : strobe.rldLoad;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) busyCnt <= '0;
      else if (loadLane) busyCnt <= BW'(SYNC_TICKS);
      else if (tickIn && busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
    assign busyFlags[g] = (busyCnt != '0);

    // R9: a pending flag only clears on a tick pulse
    assert_flag_clear_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busyFlags[g]) |-> $past(tickIn));
  end

  // R5: once started, the counter never stops
  assert_no_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);
endmodule

// File: rtl/kwdt_datapath.sv
module kwdt_datapath
  import kwdt_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int PSC_W        = 3,
  parameter int MAX_CODE     = 6,
  parameter int DIV_BASE_LOG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             running,
  input  kwdtStrobe_t      strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [PSC_W-1:0] pscVal,
  output logic [CNT_W-1:0] rldVal,
  output logic             rstReq
);
  localparam int PRE_W = DIV_BASE_LOG + MAX_CODE;
  localparam int SH_W  = $clog2(PRE_W + 1) + 1;

  logic [CNT_W-1:0] cntVal;
  logic [PRE_W-1:0] preCnt, preLimit;
  logic [PSC_W-1:0] effCode;
  logic             countTick, expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscVal <= '0;
      rldVal <= '1;
    end else begin
      if (strobe.pscLoad) pscVal <= wrData[PSC_W-1:0];
      if (strobe.rldLoad) rldVal <= wrData;
    end
  end

  // codes above the largest divider saturate to it
  assign effCode  = (pscVal > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : pscVal;
  assign preLimit = (PRE_W'(1) << (SH_W'(effCode) + SH_W'(DIV_BASE_LOG))) - PRE_W'(1);

  assign countTick = running && tickIn && (preCnt == preLimit);
  assign expire    = countTick && !strobe.cntReload && (cntVal <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cntVal <= '1;
      rstReq <= 1'b0;
    end else begin
      if (running && tickIn) preCnt <= countTick ? '0 : preCnt + 1'b1;
      if (strobe.cntReload) cntVal <= rldVal;
      else if (countTick) cntVal <= (cntVal <= CNT_W'(1)) ? rldVal : cntVal - 1'b1;
      rstReq <= expire;
    end
  end

  // R7: request lasts one cycle and finds the counter refilled
  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  assert_refilled_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> cntVal == $past(rldVal));
  // R10: no request unless running
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(running));
  // R6: idle counter holds unless reloaded
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.cntReload) |=> $stable(cntVal));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 12,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rstReq
);
  kwdtStrobe_t      strobe;
  logic             running;
  logic [1:0]       busyFlags;
  logic [PSC_W-1:0] pscVal;
  logic [CNT_W-1:0] rldVal;
  logic             unusedHi;

  assign unusedHi = ^busWdata[DATA_W-1:KEY_W];

  kwdt_ctrl #(.ADDR_W(ADDR_W), .SYNC_TICKS(SYNC_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busWr(busWr), .busAddr(busAddr),
    .keyIn(busWdata[KEY_W-1:0]), .strobe(strobe), .running(running),
    .busyFlags(busyFlags));

  kwdt_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dp_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .running(running), .strobe(strobe),
    .wrData(busWdata[CNT_W-1:0]), .pscVal(pscVal), .rldVal(rldVal), .rstReq(rstReq));

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_PSC):  busRdata[PSC_W-1:0] = pscVal;
      ADDR_W'(OFS_RLD):  busRdata[CNT_W-1:0] = rldVal;
      ADDR_W'(OFS_STAT): busRdata[1:0]       = busyFlags;
      default:           busRdata            = '0;
    endcase
  end
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb_top;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;

  int compared = 0;
  int mismatched = 0;

  // bench reference state
  bit        mAcc, mRun, mRst;
  int        mPsc, mRld, mPre, mCnt, mPb, mRb;

  keyed_watchdog dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq));

  always #10 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int divOf(int code);
    return 4 << ((code > 6) ? 6 : code);
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'h4:    return 32'(mPsc);
      4'h8:    return 32'(mRld);
      4'hC:    return {30'd0, mRb != 0, mPb != 0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelReset();
    mAcc = 0; mRun = 0; mRst = 0; mPsc = 0; mRld = 'hFFF;
    mPre = 0; mCnt = 'hFFF; mPb = 0; mRb = 0;
  endtask

  task automatic modelStep(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
    bit ct = 0;
    bit keyWr = wr && a == 4'h0;
    bit pLd = wr && a == 4'h4 && mAcc;
    bit rLd = wr && a == 4'h8 && mAcc;
    logic [15:0] key = d[15:0];
    mRst = 0;
    if (mRun && tk) begin
      if (mPre == divOf(mPsc) - 1) begin mPre = 0; ct = 1; end
      else mPre++;
    end
    if (keyWr && key == 16'hAAAA) mCnt = mRld;
    else if (ct) begin
      if (mCnt <= 1) begin mCnt = mRld; mRst = 1; end
      else mCnt--;
    end
    if (pLd) mPb = SYNC; else if (tk && mPb > 0) mPb--;
    if (rLd) mRb = SYNC; else if (tk && mRb > 0) mRb--;
    if (pLd) mPsc = int'(d[2:0]);
    if (rLd) mRld = int'(d[11:0]);
    if (keyWr) mAcc = (key == 16'h5555);
    if (keyWr && key == 16'hCCCC) mRun = 1;
  endtask

  // one clock: drive, edge, model update, sample at falling edge
  task automatic cycle(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
    busWr = wr; busAddr = a; busWdata = d; tickIn = tk;
    @(posedge clk);
    modelStep(wr, a, d, tk);
    @(negedge clk);
    check("R7 rstReq", {31'd0, rstReq}, {31'd0, mRst});
    check("R2 read", busRdata, modelRead(a));
  endtask

  task automatic doReset();
    rstN = 0; busWr = 0; tickIn = 0; busAddr = '0; busWdata = '0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic countToExpiry(output int n);
    n = 0;
    for (int k = 1; k <= 1000; k++) begin
      cycle(0, 4'h0, 0, 1);
      if (rstReq === 1'b1) begin n = k; break; end
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    doReset();
    @(negedge clk);
    // R1 reset state
    check("R1 rstReq", {31'd0, rstReq}, 32'd0);
    busAddr = 4'h4; #1 check("R1 psc", busRdata, 32'd0);
    busAddr = 4'h8; #1 check("R1 rld", busRdata, 32'hFFF);
    busAddr = 4'hC; #1 check("R1 stat", busRdata, 32'd0);
    busAddr = 4'h0; #1 check("R2 key reads zero", busRdata, 32'd0);

    // R4 locked write ignored
    cycle(1, 4'h8, 32'h5, 0);
    cycle(0, 4'h8, 0, 0);
    check("R4 locked rld", busRdata, 32'hFFF);

    // R10 refilled but not started: no request
    cycle(1, 4'h0, 32'h5555, 0);
    cycle(1, 4'h4, 32'h0, 0);
    cycle(1, 4'h8, 32'h1, 0);
    cycle(1, 4'h0, 32'hAAAA, 0);
    countToExpiry(n);
    check("R10 idle no request", 32'(n), 32'd0);

    // R9 pending flags, R2 readback
    cycle(1, 4'h0, 32'h5555, 0);
    cycle(1, 4'h4, 32'hFFFF_FFF7, 0);
    cycle(0, 4'hC, 0, 0);
    check("R9 psc pending", busRdata, 32'd1);
    cycle(1, 4'h8, 32'h0000_0002, 0);
    cycle(0, 4'hC, 0, 0);
    check("R9 both pending", busRdata, 32'd3);
    cycle(0, 4'h4, 0, 0);
    check("R2 psc code", busRdata, 32'd7);

    // R3 other key relocks
    cycle(1, 4'h0, 32'h1234, 0);
    cycle(1, 4'h8, 32'h9, 0);
    cycle(0, 4'h8, 0, 0);
    check("R3 relocked", busRdata, 32'd2);

    cycle(0, 4'hC, 0, 1);
    cycle(0, 4'hC, 0, 1);
    check("R9 flags cleared", busRdata, 32'd0);

    // R6 code 7 divides by 256, reload 2 -> 512 ticks
    cycle(1, 4'h0, 32'hAAAA, 0);
    cycle(1, 4'h0, 32'hCCCC, 0);
    countToExpiry(n);
    check("R6 expiry ticks", 32'(n), 32'd512);

    // R5 zero key does not stop
    cycle(1, 4'h0, 32'h0000, 0);
    countToExpiry(n);
    check("R5 still running", 32'(n), 32'd512);

    // R8 reload overrides expiring step
    for (int k = 0; k < 511; k++) cycle(0, 4'h0, 0, 1);
    cycle(1, 4'h0, 32'hAAAA, 1);
    check("R8 no request on reload", {31'd0, rstReq}, 32'd0);
    countToExpiry(n);
    check("R8 refill period", 32'(n), 32'd512);

    // random phase against the reference model
    doReset();
    for (int k = 0; k < 4000; k++) begin
      bit wr = ($urandom_range(0, 9) < 3);
      logic [3:0] a = 4'($urandom_range(0, 3) * 4);
      logic [31:0] d = $urandom;
      bit tk = $urandom_range(0, 1);
      if (a == 4'h0) begin
        case ($urandom_range(0, 4))
          0: d = 32'h5555;
          1: d = 32'hAAAA;
          2: d = 32'hCCCC;
          3: d = 32'h0000;
          default: ;
        endcase
      end else if (a == 4'h8) d = 32'($urandom_range(0, 6));
      else if (a == 4'h4) d = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 7)) : 32'($urandom_range(0, 1));
      cycle(wr, a, d, tk);
    end

    summary();
    $finish;
  end
endmodule